// File: doc/BRIEF.md
# Eight-Lane Oscillator Mixer with Bypass

This block moves a band-pass sample stream down to baseband. On every clock it accepts eight consecutive signed 16-bit samples and multiplies each one by a cosine from a numerically controlled oscillator. The tuning word that sets the oscillator frequency is a run-time input. The block looks the cosine values up in a precomputed synthesizable table. Each product is rounded back to 16 bits. The sine half of a full quadrature oscillator is not built, because only the real product is kept.

When the wanted band already sits at baseband, the bypass input sends the samples straight to the output. The bypass path goes through as many register stages as the mixer. Each input vector therefore leaves after the same delay in either mode, and the mode can change from one vector to the next without misaligning the lanes. The phase accumulator keeps running in both modes.

Top module: `nco_mixer`

## Requirements
- R1: While the reset input is low, every output lane reads zero.
- R2: A vector captured at clock edge t appears on `dout` just after edge t+3, a latency of four clock edges. This holds in both modes.
- R3: With `bypass` high for a vector, each output lane equals the matching input lane unchanged.
- R4: A 32-bit phase accumulator starts at zero after reset and advances by 8 x `freq_word` at every edge. Lane j of the vector captured at an edge uses the accumulator value before that edge plus j x `freq_word`, taken modulo 2^32.
- R5: Table entry k, for k from 0 to 1023, is round(32767 x cos(2*pi*k/1024)), with halves rounded away from zero. The entry is selected by phase bits [31:22].
- R6: In mixer mode each lane outputs bits [30:15] of (x*c + 2^14), where x is the signed sample and c is the signed table entry.
- R7: The mode is taken per vector. Alternating `bypass` on consecutive vectors gives each vector the treatment of its own mode, at the same latency.
- R8: With `freq_word` at zero the phase stays constant, so every lane is scaled by the same table entry.
- R9: The accumulator and lane phases wrap modulo 2^32 for tuning words with the top bit set.
- R10: Lane j occupies bits [16j+15:16j] of both `din` and `dout`. Lane 0 is the earliest sample in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bypass | input | 1 | 1: pass samples through; 0: mix with the oscillator |
| freq_word | input | 32 | Phase increment per sample |
| din | input | 128 | Eight signed 16-bit input lanes |
| dout | output | 128 | Eight signed 16-bit output lanes |

## Verification
Some behaviours are checked on every cycle. Outputs are held at zero during reset. A bypassed vector reappears exactly four edges later. A zero vector in mixer mode gives a zero result four edges later. The accumulator steps by eight tuning words per edge.

Other behaviours only the bench's scenarios can show. These are the table contents, the per-lane phase offsets, the rounding of products (including full-scale samples), the wrap with large tuning words, and the correct per-vector treatment when the mode alternates. The bench compares against a reference built from its own cosine table.

// File: rtl/nco_mixer_pkg.sv
package nco_mixer_pkg;
  parameter int LANES_DEF = 8;
  parameter int SAMPLE_W_DEF = 16;
  parameter int PHASE_W_DEF = 32;
  parameter int ADDR_W_DEF = 10;
  parameter int COS_W_DEF = 16;

  // Rounded cosine sample for table slot k, full scale 2^(cw-1)-1.
  function automatic logic signed [31:0] cos_entry(input int k, input int aw, input int cw);
    real amp;
    real ang;
    real v;
    int  r;
    amp = (2.0 ** (cw - 1)) - 1.0;
    ang = 2.0 * 3.14159265358979323846 * real'(k) / (2.0 ** aw);
    v = amp * $cos(ang);
    if (v >= 0.0) r = $rtoi(v + 0.5);
    else          r = -$rtoi(0.5 - v);
    return 32'(r);
  endfunction
endpackage

// File: rtl/nco_phase.sv
module nco_phase #(
  parameter int LANES   = 8,
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PHASE_W-1:0]        fw,
  output logic [PHASE_W-1:0]        base_ph,
  output logic [LANES*ADDR_W-1:0]   addr_bus
);
  localparam int SHIFT = PHASE_W - ADDR_W;

  logic [PHASE_W-1:0]      acc_q, acc_d;
  logic [LANES*ADDR_W-1:0] addr_d, addr_q;

  always_comb begin
    acc_d = acc_q + PHASE_W'(LANES) * fw;
    for (int j = 0; j < LANES; j++) begin
      addr_d[j*ADDR_W +: ADDR_W] = ADDR_W'((acc_q + PHASE_W'(j) * fw) >> SHIFT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      addr_q <= '0;
    end else begin
      acc_q  <= acc_d;
      addr_q <= addr_d;
    end
  end

  assign base_ph  = acc_q;
  assign addr_bus = addr_q;
endmodule

// File: rtl/nco_cos_rom.sv
module nco_cos_rom
  import nco_mixer_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int ADDR_W = 10,
  parameter int COS_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*ADDR_W-1:0] addr_bus,
  output logic [LANES*COS_W-1:0]  cos_bus
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [COS_W-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
    localparam logic signed [31:0] VAL = cos_entry(k, ADDR_W, COS_W);
    assign tbl[k] = VAL[COS_W-1:0];
  end

  logic [LANES*COS_W-1:0] cos_d;

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      cos_d[j*COS_W +: COS_W] = tbl[addr_bus[j*ADDR_W +: ADDR_W]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cos_bus <= '0;
    else        cos_bus <= cos_d;
  end
endmodule

// File: rtl/mix_lane.sv
module mix_lane #(
  parameter int SAMPLE_W = 16,
  parameter int COS_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] x,
  input  logic [COS_W-1:0]    c,
  input  logic                byp,
  output logic [SAMPLE_W-1:0] y
);
  localparam int PROD_W = SAMPLE_W + COS_W;
  localparam int SH     = COS_W - 1;

  logic signed [PROD_W-1:0] prod_d, prod_q, rnd;
  logic [SAMPLE_W-1:0]      x_q, y_d;
  logic                     byp_q;

  always_comb begin
    prod_d = $signed(x) * $signed(c);
    rnd    = prod_q + (PROD_W'(1) <<< (SH - 1));
    y_d    = byp_q ? x_q : rnd[SH +: SAMPLE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      x_q    <= '0;
      byp_q  <= 1'b0;
      y      <= '0;
    end else begin
      prod_q <= prod_d;
      x_q    <= x;
      byp_q  <= byp;
      y      <= y_d;
    end
  end
endmodule

// File: rtl/nco_mixer.sv
module nco_mixer
  import nco_mixer_pkg::*;
#(
  parameter int LANES    = LANES_DEF,
  parameter int SAMPLE_W = SAMPLE_W_DEF,
  parameter int PHASE_W  = PHASE_W_DEF,
  parameter int ADDR_W   = ADDR_W_DEF,
  parameter int COS_W    = COS_W_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bypass,
  input  logic [PHASE_W-1:0]        freq_word,
  input  logic [LANES*SAMPLE_W-1:0] din,
  output logic [LANES*SAMPLE_W-1:0] dout
);
  localparam int BUS_W = LANES * SAMPLE_W;

  // reset synchronizer: asserts at once, releases on the clock
  logic rs_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs_meta    <= 1'b1;
      rst_sync_n <= rs_meta;
    end
  end

  logic [PHASE_W-1:0]      base_ph;
  logic [LANES*ADDR_W-1:0] addr_bus;
  logic [LANES*COS_W-1:0]  cos_bus;
  logic [BUS_W-1:0]        din_s1, din_s2;
  logic                    byp_s1, byp_s2;

  nco_phase #(.LANES(LANES), .PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_phase (
    .clk(clk), .rst_n(rst_sync_n), .fw(freq_word),
    .base_ph(base_ph), .addr_bus(addr_bus)
  );

  nco_cos_rom #(.LANES(LANES), .ADDR_W(ADDR_W), .COS_W(COS_W)) u_rom (
    .clk(clk), .rst_n(rst_sync_n), .addr_bus(addr_bus), .cos_bus(cos_bus)
  );

  // sample and mode alignment with the phase and table stages
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      din_s1 <= '0;
      din_s2 <= '0;
      byp_s1 <= 1'b0;
      byp_s2 <= 1'b0;
    end else begin
      din_s1 <= din;
      din_s2 <= din_s1;
      byp_s1 <= bypass;
      byp_s2 <= byp_s1;
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    mix_lane #(.SAMPLE_W(SAMPLE_W), .COS_W(COS_W)) u_mix (
      .clk(clk), .rst_n(rst_sync_n),
      .x(din_s2[j*SAMPLE_W +: SAMPLE_W]),
      .c(cos_bus[j*COS_W +: COS_W]),
      .byp(byp_s2),
      .y(dout[j*SAMPLE_W +: SAMPLE_W])
    );
  end
endmodule

// File: rtl/nco_mixer_chk.sv
module nco_mixer_chk #(
  parameter int BUS_W   = 128,
  parameter int PHASE_W = 32,
  parameter int LANES   = 8
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               bypass,
  input logic [PHASE_W-1:0] freq_word,
  input logic [BUS_W-1:0]   din,
  input logic [BUS_W-1:0]   dout,
  input logic [PHASE_W-1:0] base_ph
);
  logic [2:0] run_cnt;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)        run_cnt <= '0;
    else if (run_cnt != 3'd7) run_cnt <= run_cnt + 3'd1;
  end

  // R1: outputs stay zero while the internal reset is held
  p_reset_zero_r1: assert property (@(posedge clk)
    $past(!rst_sync_n) && !rst_sync_n |-> dout == '0);

  // R3: bypassed vector comes back unchanged four edges later
  p_bypass_echo_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    run_cnt >= 3'd5 && $past(bypass, 4) |-> dout == $past(din, 4));

  // R2: zero vector in mixer mode yields zero at the fixed latency
  p_mix_zero_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    run_cnt >= 3'd5 && !$past(bypass, 4) && $past(din, 4) == '0 |-> dout == '0);

  // R4: accumulator advances by lanes x tuning word per edge
  p_acc_step_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    run_cnt >= 3'd2 |-> base_ph - $past(base_ph) == PHASE_W'(LANES) * $past(freq_word));
endmodule

bind nco_mixer nco_mixer_chk #(
  .BUS_W(LANES * SAMPLE_W), .PHASE_W(PHASE_W), .LANES(LANES)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .bypass(bypass), .freq_word(freq_word),
  .din(din), .dout(dout), .base_ph(base_ph)
);

// File: tb/tb_nco_mixer.sv
`timescale 1ns/1ps
module tb_nco_mixer;
  logic         clk;
  logic         rst_n;
  logic         bypass;
  logic [31:0]  freq_word;
  logic [127:0] din;
  logic [127:0] dout;

  int errors = 0;
  int checks = 0;
  logic [31:0] m_acc = '0;   // reference accumulator
  logic [127:0] exp_q [64];
  logic done = 1'b0;

  nco_mixer dut (.clk(clk), .rst_n(rst_n), .bypass(bypass),
                 .freq_word(freq_word), .din(din), .dout(dout));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] ref_cos(input int k);
    real v;
    int r;
    v = 32767.0 * $cos(2.0 * 3.14159265358979323846 * real'(k) / 1024.0);
    if (v >= 0.0) r = $rtoi(v + 0.5);
    else          r = -$rtoi(0.5 - v);
    return 16'(r);
  endfunction

  function automatic logic [15:0] ref_mix(input logic [15:0] x, input logic [15:0] c);
    longint p;
    longint r;
    p = longint'($signed(x)) * longint'($signed(c));
    r = (p + 16384) >>> 15;
    return 16'(r);
  endfunction

  function automatic logic [15:0] pat(input int seed, input int k, input int j);
    int h;
    case ((k + j + seed) % 5)
      0: return 16'h7FFF;
      1: return 16'h8000;
      default: begin
        h = seed * 7919 + k * 1031 + j * 977 + (k * j) * 37;
        return 16'(h ^ (h >> 5));
      end
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  // mode_kind: 0 mixer, 1 bypass, 2 alternating (even vectors bypassed)
  task automatic stream(input string req, input int n, input logic [31:0] f,
                        input int mode_kind, input int seed);
    for (int k = 0; k < n + 4; k++) begin
      logic [127:0] v;
      logic [127:0] e;
      logic         b;
      @(negedge clk);
      if (k >= 4) check(req, dout, exp_q[(k - 4) % 64]);
      b = (mode_kind == 1) || (mode_kind == 2 && k[0] == 1'b0);
      for (int j = 0; j < 8; j++) begin
        logic [31:0] ph;
        v[j*16 +: 16] = (k < n) ? pat(seed, k, j) : 16'h0;
        ph = m_acc + 32'(j) * f;
        e[j*16 +: 16] = b ? v[j*16 +: 16] : ref_mix(v[j*16 +: 16], ref_cos(int'(ph[31:22])));
      end
      din = v; bypass = b; freq_word = f;
      exp_q[k % 64] = e;
      m_acc = m_acc + 32'd8 * f;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bypass = 1'b0; freq_word = '0; din = '1;
    repeat (3) @(negedge clk);
    check("R1 reset", dout, '0);
    rst_n = 1'b1;
    din = '0;
    repeat (6) @(negedge clk);
    check("R1 after release", dout, '0);
  endtask

  // R2: bypass impulse with a zero tuning word, watch each edge
  task automatic t_latency;
    @(negedge clk);
    bypass = 1'b1; freq_word = '0; din = {8{16'h1234}};
    @(negedge clk);
    din = '0;
    check("R2 edge1", dout, '0);
    @(negedge clk); check("R2 edge2", dout, '0);
    @(negedge clk); check("R2 edge3", dout, '0);
    @(negedge clk); check("R2 edge4", dout, {8{16'h1234}});
    @(negedge clk); check("R2 edge5", dout, '0);
    bypass = 1'b0;
  endtask

  task automatic t_mix_tone;   stream("R4 R5 R6 R10 mixer tone", 40, 32'h00C0_0000, 0, 1); endtask
  task automatic t_mix_fine;   stream("R4 R6 fine step", 30, 32'h0001_2345, 0, 2); endtask
  task automatic t_bypass;     stream("R3 bypass", 20, 32'h0300_0000, 1, 3); endtask
  task automatic t_alternate;  stream("R7 alternating mode", 30, 32'h0210_0000, 2, 4); endtask
  task automatic t_zero_freq;  stream("R8 zero tuning", 16, 32'h0, 0, 5); endtask
  task automatic t_wrap;       stream("R9 wrap", 40, 32'hF123_4567, 0, 6); endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_mix_tone();
    t_mix_fine();
    t_bypass();
    t_alternate();
    t_zero_freq();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule